// File: doc/BRIEF.md
# Binary tree walker hash engine

This block steers one walker through a binary tree held as an implicit array: node `i` has its left child at `2i+1` and its right child at `2i+2`, and the root is index 0. A start command loads the walker's 32-bit value and places the walker at the root. The block then runs a fixed number of rounds. In each round it reads the current node's value through a single-request memory port and XORs that value into the walker's value. The result passes through a six-stage hash, and the lowest bit of the hash picks the next child.

The tree is ten levels deep below the root, so it holds 2047 nodes. A step that would leave the deepest level sends the walker back to the root. Each hash stage is registered. A round therefore takes one request cycle, plus the memory latency, plus six hash cycles. A one-cycle `done` pulse marks the end of the walk and shows the final value and node index.

Top module: `tree_walk_hasher`

## Requirements
- R1: After reset, `done` and `mem_req` are 0, and `result_val` and `result_idx` are 0.
- R2: A `start` pulse while idle loads `init_val` as the walker value. In the next cycle the block raises `mem_req` with `mem_addr` equal to 0, which is the root.
- R3: `mem_req` is high for exactly one cycle per round. No new request is raised until the data for the previous request has returned and its hash has completed.
- R4: In each round the walker value `a` becomes `a ^ node`, where `node` is the returned word. It then passes through six stages in this order, with all arithmetic modulo 2^32: `a*4097 + 0x3C6EF372`; `a ^ 0x5BD1E995 ^ (a >> 19)`; `a*33 + 0x27D4EB2F`; `a ^ 0x165667B1 ^ (a >> 9)`; `a*9 + 0x9E3779B9`; `a ^ 0x85EBCA6B ^ (a >> 16)`.
- R5: If the round's hash result is even, the next index is `2i+1`. If it is odd, the next index is `2i+2`.
- R6: If the child index would be 2047 or more (a level below depth 10), the next index is 0. Every walk therefore revisits the root at its twelfth request.
- R7: `done` is high for exactly one cycle, in the cycle after the sixteenth round completes. At that time `result_val` and `result_idx` hold the final walker value and node index, and they keep those values while the block is idle.
- R8: For a memory whose `mem_rvalid` arrives L cycles after the request is sampled, consecutive requests are L+7 cycles apart. `done` rises 16·(L+7) cycles after the cycle in which `start` was sampled.
- R9: `start` is ignored while a walk is in progress. The result, index sequence and timing are those of the walk already running.
- R10: Whenever `mem_req` is high, `mem_addr` is below 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (sampled only while idle) |
| init_val | input | 32 | Walker value at the start of the walk |
| mem_req | output | 1 | Node read request, one-cycle pulse |
| mem_addr | output | 11 | Index of the node being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Node value returned for the last request |
| done | output | 1 | One-cycle pulse after the final round |
| result_val | output | 32 | Walker value after the most recent update |
| result_idx | output | 11 | Node index after the most recent update |

## Verification
Walks are started from several seeds: zero, all ones and mixed bit patterns. Each seed gives a different chain of hash parities, so a wrong stage constant, stage order or child choice shows up in the first request address that differs. Each seed is run at memory latencies of 1, 2 and 5 cycles. This separates a correct wait on `mem_rvalid` from a fixed schedule, because a fixed schedule puts every request, and the `done` pulse, on the wrong cycle at some latency. Since every walk reaches below depth 10 during its eleventh round, the twelfth request always checks the return to the root. A second `start` issued in the middle of a walk with a different seed shows whether a running walk is protected from restart.

// File: rtl/twh_pkg.sv
package twh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_HASH = 2'd3
    } walk_state_e;

    localparam int unsigned HASH_STAGES = 6;

endpackage

// File: rtl/twh_hash_stage.sv
module twh_hash_stage #(
    parameter int unsigned          DATA_W = 32,
    parameter bit                   AFFINE = 1'b1,
    parameter logic [DATA_W-1:0]    MUL    = '0,
    parameter logic [DATA_W-1:0]    KEY    = '0,
    parameter int unsigned          SHIFT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic              vld_d, vld_q;
    logic [DATA_W-1:0] dat_d, dat_q;
    logic [DATA_W-1:0] mix;

    generate
        if (AFFINE) begin : g_affine
            always_comb mix = (in_data * MUL) + KEY;
        end else begin : g_xorshift
            always_comb mix = in_data ^ KEY ^ (in_data >> SHIFT);
        end
    endgenerate

    always_comb begin
        vld_d = in_valid;
        dat_d = in_valid ? mix : dat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= vld_d;
            dat_q <= dat_d;
        end
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;

endmodule

// File: rtl/twh_hash_pipe.sv
module twh_hash_pipe #(
    parameter int unsigned                DATA_W  = 32,
    parameter logic [2:0][DATA_W-1:0]     AFF_MUL = '0,
    parameter logic [2:0][DATA_W-1:0]     AFF_ADD = '0,
    parameter logic [2:0][DATA_W-1:0]     XS_KEY  = '0,
    parameter logic [2:0][5:0]            XS_SH   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    import twh_pkg::*;

    logic              vld [HASH_STAGES+1];
    logic [DATA_W-1:0] dat [HASH_STAGES+1];

    assign vld[0] = in_valid;
    assign dat[0] = in_data;

    generate
        for (genvar s = 0; s < HASH_STAGES; s++) begin : g_stage
            localparam bit          IS_AFF = ((s % 2) == 0);
            localparam int unsigned J      = s / 2;
            twh_hash_stage #(
                .DATA_W (DATA_W),
                .AFFINE (IS_AFF),
                .MUL    (AFF_MUL[J]),
                .KEY    (IS_AFF ? AFF_ADD[J] : XS_KEY[J]),
                .SHIFT  (int'(XS_SH[J]))
            ) i_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (vld[s]),
                .in_data   (dat[s]),
                .out_valid (vld[s+1]),
                .out_data  (dat[s+1])
            );
        end
    endgenerate

    assign out_valid = vld[HASH_STAGES];
    assign out_data  = dat[HASH_STAGES];

endmodule

// File: rtl/twh_walk_ctrl.sv
module twh_walk_ctrl #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned MAX_DEPTH = 10,
    parameter int unsigned ROUNDS    = 16,
    localparam int unsigned IDX_W    = MAX_DEPTH + 1,
    localparam int unsigned RND_W    = $clog2(ROUNDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] init_val,
    output logic              mem_req,
    output logic [IDX_W-1:0]  mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              hash_in_valid,
    output logic [DATA_W-1:0] hash_in_data,
    input  logic              hash_valid,
    input  logic [DATA_W-1:0] hash_data,
    output logic              done,
    output logic [DATA_W-1:0] result_val,
    output logic [IDX_W-1:0]  result_idx
);

    import twh_pkg::*;

    localparam logic [IDX_W:0]   NODE_COUNT = (IDX_W+1)'((1 << (MAX_DEPTH + 1)) - 1);
    localparam logic [IDX_W-1:0] FIRST_LEAF = IDX_W'((1 << MAX_DEPTH) - 1);
    localparam logic [RND_W-1:0] LAST_RND   = RND_W'(ROUNDS - 1);

    typedef struct packed {
        walk_state_e       st;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] val;
        logic [RND_W-1:0]  rnd;
        logic              done;
    } walk_regs_t;

    walk_regs_t q, d;
    logic [IDX_W:0] child_w;

    always_comb begin
        child_w = {q.idx, 1'b0} + (IDX_W+1)'(1) + {{IDX_W{1'b0}}, hash_data[0]};
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.val = init_val;
                    d.idx = '0;
                    d.rnd = '0;
                    d.st  = ST_REQ;
                end
            end
            ST_REQ: begin
                d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    d.st = ST_HASH;
                end
            end
            ST_HASH: begin
                if (hash_valid) begin
                    d.val = hash_data;
                    d.idx = (child_w >= NODE_COUNT) ? '0 : child_w[IDX_W-1:0];
                    if (q.rnd == LAST_RND) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.rnd = q.rnd + RND_W'(1);
                        d.st  = ST_REQ;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, idx: '0, val: '0, rnd: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign mem_req       = (q.st == ST_REQ);
    assign mem_addr      = q.idx;
    assign hash_in_valid = (q.st == ST_WAIT) && mem_rvalid;
    assign hash_in_data  = q.val ^ mem_rdata;
    assign done          = q.done;
    assign result_val    = q.val;
    assign result_idx    = q.idx;

    // R2: a start taken while idle leads straight to a root request
    a_r2_first_req_root: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start) |=> (mem_req && mem_addr == '0));

    // R3: a request never lasts longer than one cycle
    a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R3: a hash result only arrives while the walk waits for it
    a_r3_hash_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        hash_valid |-> (q.st == ST_HASH));

    // R5: an even hash taken above the last level lands on an odd (left) index
    a_r5_left_child_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HASH && hash_valid && !hash_data[0] && q.idx < FIRST_LEAF)
        |=> q.idx[0]);

    // R6: stepping off the deepest level returns the walker to the root
    a_r6_overflow_root: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HASH && hash_valid && q.idx >= FIRST_LEAF) |=> (q.idx == '0));

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: requested addresses stay inside the tree
    a_r10_addr_in_tree: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ({1'b0, mem_addr} < NODE_COUNT));

endmodule

// File: rtl/tree_walk_hasher.sv
module tree_walk_hasher #(
    parameter int unsigned              DATA_W    = 32,
    parameter int unsigned              MAX_DEPTH = 10,
    parameter int unsigned              ROUNDS    = 16,
    parameter logic [2:0][DATA_W-1:0]   AFF_MUL   = {DATA_W'(9), DATA_W'(33), DATA_W'(4097)},
    parameter logic [2:0][DATA_W-1:0]   AFF_ADD   = {DATA_W'(32'h9E3779B9), DATA_W'(32'h27D4EB2F),
                                                     DATA_W'(32'h3C6EF372)},
    parameter logic [2:0][DATA_W-1:0]   XS_KEY    = {DATA_W'(32'h85EBCA6B), DATA_W'(32'h165667B1),
                                                     DATA_W'(32'h5BD1E995)},
    parameter logic [2:0][5:0]          XS_SH     = {6'd16, 6'd9, 6'd19},
    localparam int unsigned             IDX_W     = MAX_DEPTH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] init_val,
    output logic              mem_req,
    output logic [IDX_W-1:0]  mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] result_val,
    output logic [IDX_W-1:0]  result_idx
);

    logic              h_in_valid;
    logic [DATA_W-1:0] h_in_data;
    logic              h_out_valid;
    logic [DATA_W-1:0] h_out_data;

    twh_walk_ctrl #(
        .DATA_W    (DATA_W),
        .MAX_DEPTH (MAX_DEPTH),
        .ROUNDS    (ROUNDS)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .init_val      (init_val),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .hash_in_valid (h_in_valid),
        .hash_in_data  (h_in_data),
        .hash_valid    (h_out_valid),
        .hash_data     (h_out_data),
        .done          (done),
        .result_val    (result_val),
        .result_idx    (result_idx)
    );

    twh_hash_pipe #(
        .DATA_W  (DATA_W),
        .AFF_MUL (AFF_MUL),
        .AFF_ADD (AFF_ADD),
        .XS_KEY  (XS_KEY),
        .XS_SH   (XS_SH)
    ) i_hash (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (h_in_valid),
        .in_data   (h_in_data),
        .out_valid (h_out_valid),
        .out_data  (h_out_data)
    );

endmodule

// File: tb/test_tree_walk_hasher.sv
module test_tree_walk_hasher;

    localparam int CLK_PERIOD = 10;
    localparam int ROUNDS     = 16;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] init_val = '0;
    logic        mem_req;
    logic [10:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] result_val;
    logic [10:0] result_idx;

    int compared   = 0;
    int mismatched = 0;
    int lat        = 1;
    int wd_cnt     = 0;

    // expected walk, filled by the behavioural model
    int          exp_addr [ROUNDS];
    logic [31:0] exp_val;
    int          exp_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    tree_walk_hasher i_tree_walk_hasher (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .init_val   (init_val),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .result_val (result_val),
        .result_idx (result_idx)
    );

    function automatic logic [31:0] node_word(int a);
        logic [31:0] x;
        x = 32'(a) * 32'h01000193;
        return x ^ 32'hA5A55A5A;
    endfunction

    // memory with a programmable read latency
    int          mcnt = 0;
    int          maddr = 0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            maddr <= int'(mem_addr);
            if (lat == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= node_word(int'(mem_addr));
            end else begin
                mcnt <= lat - 1;
            end
        end else if (mcnt > 0) begin
            mcnt <= mcnt - 1;
            if (mcnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= node_word(maddr);
            end
        end
    end

    function automatic logic [31:0] hash6(logic [31:0] a0);
        logic [31:0] a;
        a = a0;
        a = (a + 32'h3C6EF372) + (a << 12);
        a = a ^ 32'h5BD1E995 ^ (a >> 19);
        a = (a + 32'h27D4EB2F) + (a << 5);
        a = a ^ 32'h165667B1 ^ (a >> 9);
        a = (a + 32'h9E3779B9) + (a << 3);
        a = a ^ 32'h85EBCA6B ^ (a >> 16);
        return a;
    endfunction

    task automatic build_model(logic [31:0] seed);
        logic [31:0] v;
        int idx;
        int depth;
        v = seed;
        idx = 0;
        depth = 0;
        for (int r = 0; r < ROUNDS; r++) begin
            exp_addr[r] = idx;
            v = hash6(v ^ node_word(idx));
            depth = depth + 1;
            idx = 2 * idx + (v[0] ? 2 : 1);
            if (depth > 10) begin
                idx = 0;
                depth = 0;
            end
        end
        exp_val = v;
        exp_idx = idx;
    endtask

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // runs one walk, comparing every cycle against the model
    task automatic run_walk(logic [31:0] seed, int latency, bit poke);
        int p;
        int total;
        lat = latency;
        build_model(seed);
        p = latency + 7;
        total = ROUNDS * p;
        @(negedge clk);
        start = 1'b1;
        init_val = seed;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc <= total + 1; cyc++) begin
            bit want_req;
            want_req = (cyc % p == 0) && (cyc < total);
            // R3 R8: request cadence
            chk(mem_req == want_req, "R8", "mem_req", longint'(mem_req), longint'(want_req));
            if (want_req && mem_req) begin
                if (cyc == 0)
                    chk(mem_addr == 11'd0, "R2", "first address", longint'(mem_addr), 0);
                else if (cyc / p == 11)
                    chk(int'(mem_addr) == exp_addr[11] && exp_addr[11] == 0, "R6",
                        "root after overflow", longint'(mem_addr), longint'(exp_addr[11]));
                else
                    chk(int'(mem_addr) == exp_addr[cyc / p], "R5", "child address",
                        longint'(mem_addr), longint'(exp_addr[cyc / p]));
                chk(mem_addr < 11'd2047, "R10", "address range", longint'(mem_addr), 2046);
            end
            chk(done == (cyc == total), "R7", "done pulse", longint'(done),
                longint'(cyc == total));
            if (cyc >= total) begin
                chk(result_val == exp_val, "R4", "final value", longint'(result_val),
                    longint'(exp_val));
                chk(int'(result_idx) == exp_idx, "R7", "final index", longint'(result_idx),
                    longint'(exp_idx));
            end
            if (poke && cyc == 20) begin
                // R9: a second start with a different seed mid-walk
                start = 1'b1;
                init_val = ~seed;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    always @(posedge clk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt >= WATCHDOG) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", wd_cnt, WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1", "done", longint'(done), 0);
        chk(mem_req == 1'b0, "R1", "mem_req", longint'(mem_req), 0);
        chk(result_val == 32'd0, "R1", "result_val", longint'(result_val), 0);
        chk(result_idx == 11'd0, "R1", "result_idx", longint'(result_idx), 0);

        run_walk(32'h0000_0000, 1, 1'b0);
        run_walk(32'hFFFF_FFFF, 2, 1'b0);
        run_walk(32'h1234_5678, 5, 1'b0);
        run_walk(32'hDEAD_BEEF, 1, 1'b0);
        run_walk(32'h8000_0001, 3, 1'b1);   // R9
        run_walk(32'h0F0F_A5A5, 2, 1'b1);   // R9

        // R7: results held while idle
        build_model(32'h0F0F_A5A5);
        repeat (3) @(negedge clk);
        chk(result_val == exp_val, "R7", "held value", longint'(result_val), longint'(exp_val));
        chk(int'(result_idx) == exp_idx, "R7", "held index", longint'(result_idx),
            longint'(exp_idx));

        summary();
        $finish;
    end

endmodule